// File: doc/BRIEF.md
# Serial Register-Access Host Controller

This block is the host side of a four-wire serial link to a single peripheral that holds multi-byte registers. A request names a five-bit register address, a direction, a byte count of one to three and, for writes, the data. The controller lowers chip-select and shifts out a command byte. For a write, the data bytes follow. For a read, it clocks the peripheral's data bytes in. All bytes go most significant byte first and MSB first within each byte. When the transfer is over, it raises chip-select and reports the result with a one-cycle response pulse.

The peripheral is slow. It needs long idle gaps between bytes and a long rest between transfers, and it wants data stable around the falling SCLK edge. Every interval is a system-clock cycle count held in a parameter. The defaults suit a 125 MHz clock:

| Parameter | Default | Time |
|---|---|---|
| `HALF_CYC` | 19 | 152 ns per SCLK phase |
| `CSS_CYC` | 3 | chip-select setup |
| `CSH_CYC` | 13 | chip-select hold |
| `GAP_CYC` | 500 | 4 µs between bytes |
| `XFER_CYC` | 800 | 6.4 µs between transfers |

SCLK rests high. The host changes MOSI only together with a rising SCLK edge, and the peripheral latches MOSI on the falling edge. The host samples MISO on the falling edge that follows the rising edge at which the peripheral drove it.

The request side is a valid/ready stream. A request is taken in a cycle where `req_valid` and `req_ready` are both high, and its fields matter only in that cycle. A requester holds `req_valid` until it is taken. `req_valid` asserted while `req_ready` is low is neither taken nor queued. The response side has no back-pressure: `rsp_valid` is a one-cycle strobe, and the requester must accept `rsp_rdata` in that cycle.

Top module: `sreg_host`

## Requirements
- R1: During and after reset, with no request, `ser_cs_n`=1, `ser_clk`=1, `ser_mosi`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken only when `req_valid` and `req_ready` are high together. In the next cycle `req_ready` is 0 and `ser_cs_n` is 0. Requests presented while `req_ready` is 0 start no transfer and leave the running transfer's bytes unchanged.
- R3: The first byte of every transfer is the command byte: bit 7 = 1 for a write and 0 for a read, bits 6 and 5 = 0, bits 4..0 = `req_addr`.
- R4: A write of n bytes sends `req_wdata[8n-1:0]` after the command byte, most significant byte first and MSB first. Bits above 8n are not sent.
- R5: A read of n bytes drives `ser_mosi`=0 during its data bytes. `rsp_rdata` holds the 8n bits sampled from `ser_miso`, in arrival order, right-aligned with zeros above. After a write, `rsp_rdata` is 0.
- R6: While `ser_cs_n` stays low, `ser_mosi` changes only in the cycle in which `ser_clk` rises, so it is stable across every falling edge.
- R7: Within a byte, every SCLK high phase and every SCLK low phase lasts exactly `HALF_CYC` cycles.
- R8: The first falling SCLK edge comes exactly `CSS_CYC`+`HALF_CYC` cycles after `ser_cs_n` falls.
- R9: Between consecutive bytes of one transfer, including after the command byte of a read, SCLK stays high for exactly `GAP_CYC`+`HALF_CYC` cycles, from the last rising edge of one byte to the first falling edge of the next.
- R10: `ser_cs_n` rises exactly `HALF_CYC`+`CSH_CYC` cycles after the last falling SCLK edge, with `ser_clk` high.
- R11: `rsp_valid` is high for exactly one cycle per transfer, in the same cycle that `ser_cs_n` is first seen high, and at no other time.
- R12: `req_ready` returns to 1 exactly `XFER_CYC` cycles after `ser_cs_n` rises, so `ser_cs_n` stays high for at least `XFER_CYC` cycles between transfers.
- R13: A `req_count` of 0 is handled as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_count | input | 2 | Byte count, 1 to 3 (0 acts as 1) |
| req_wdata | input | 24 | Write data, right-aligned to the byte count |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 24 | Read word, right-aligned; 0 after a write |
| ser_cs_n | output | 1 | Chip-select, active low |
| ser_clk | output | 1 | Serial clock, rests high |
| ser_mosi | output | 1 | Host-to-peripheral data |
| ser_miso | input | 1 | Peripheral-to-host data |

## Verification
Every output comes from a register, so each result is due a fixed number of clock edges after the event that causes it:
- the SCLK phases, chip-select setup and hold, byte gaps and rest period follow the exact counts in R7 to R10 and R12;
- `rsp_valid` and the read word appear in the same cycle chip-select rises;
- `req_ready` falls one edge after acceptance.

The bench samples all outputs on the falling clock edge, away from the edge that updates them. It runs counters of samples since each chip-select and SCLK transition, and compares each interval against its exact expected count at the sample where the transition is first seen. It compares captured bytes and read words only at the sample after the response strobe, when the whole transfer has been recorded.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_HOLD,
    ST_REST
  } sreg_state_e;

  function automatic logic [7:0] make_cmd(input logic wr, input logic [4:0] addr);
    return {wr, 2'b00, addr};
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sreg_gap_timer.sv
module sreg_gap_timer #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R7: an idle, expired counter stays expired until reloaded
  a_r7_stay_expired: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> expired);

endmodule

// File: rtl/sreg_tx_shift.sv
module sreg_tx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              shift,
  output logic              mosi
);

  logic [BYTE_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= load_byte;
    end else if (shift) begin
      q <= {q[BYTE_W-2:0], 1'b0};
    end
  end

  assign mosi = q[BYTE_W-1];

  // R6: without a load or shift strobe the line holds its value
  a_r6_line_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !shift |=> $stable(mosi));

endmodule

// File: rtl/sreg_rx_collect.sv
module sreg_rx_collect #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              bit_in,
  output logic [DATA_W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (clear) begin
      word <= '0;
    end else if (sample) begin
      word <= {word[DATA_W-2:0], bit_in};
    end
  end

  // R5: the collector is never cleared and sampled in the same cycle
  a_r5_clear_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && sample));

endmodule

// File: rtl/sreg_host.sv
module sreg_host
  import sreg_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 3,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned HALF_CYC  = 19,
  parameter int unsigned CSS_CYC   = 3,
  parameter int unsigned CSH_CYC   = 13,
  parameter int unsigned GAP_CYC   = 500,
  parameter int unsigned XFER_CYC  = 800
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [$clog2(MAX_BYTES+1)-1:0] req_count,
  input  logic [MAX_BYTES*BYTE_W-1:0]   req_wdata,
  output logic                          rsp_valid,
  output logic [MAX_BYTES*BYTE_W-1:0]   rsp_rdata,
  output logic                          ser_cs_n,
  output logic                          ser_clk,
  output logic                          ser_mosi,
  input  logic                          ser_miso
);

  localparam int unsigned DATA_W  = MAX_BYTES * BYTE_W;
  localparam int unsigned CNT_W   = $clog2(MAX_BYTES + 1);
  localparam int unsigned BIT_W   = $clog2(BYTE_W);
  localparam int unsigned TMR_MAX = max2(max2(max2(HALF_CYC, CSS_CYC), max2(CSH_CYC, GAP_CYC)), XFER_CYC);
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  localparam logic [TMR_W-1:0] T_HALF = TMR_W'(HALF_CYC - 1);
  localparam logic [TMR_W-1:0] T_CSS  = TMR_W'(CSS_CYC - 1);
  localparam logic [TMR_W-1:0] T_CSH  = TMR_W'(CSH_CYC - 1);
  localparam logic [TMR_W-1:0] T_GAP  = TMR_W'(GAP_CYC - 1);
  localparam logic [TMR_W-1:0] T_XFER = TMR_W'(XFER_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  sreg_state_e state, state_d;
  logic [BIT_W-1:0] bitc, bit_d;
  logic [CNT_W-1:0] left, left_d, eff_count;
  logic             wr_q, wr_d;
  logic             rdp_q, rdp_d;
  logic [DATA_W-1:0] wd_q, wd_d;
  logic             sclk_q, sclk_d;
  logic             cs_n_q, cs_d;
  logic             done_q, done_d;
  logic [BYTE_W-1:0] data_byte;

  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             tx_load, tx_shift;
  logic [BYTE_W-1:0] tx_byte;
  logic             rx_clear, rx_sample;

  sreg_gap_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  sreg_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (tx_load),
    .load_byte (tx_byte),
    .shift     (tx_shift),
    .mosi      (ser_mosi)
  );

  sreg_rx_collect #(.DATA_W(DATA_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (rx_clear),
    .sample (rx_sample),
    .bit_in (ser_miso),
    .word   (rsp_rdata)
  );

  // count 0 is taken as a single byte
  assign eff_count = (req_count == '0) ? CNT_W'(1) : req_count;

  // pick the write byte whose position matches the number of bytes still to send
  always_comb begin
    data_byte = '0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      if (left == CNT_W'(k + 1)) data_byte = wd_q[k*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    state_d   = state;
    bit_d     = bitc;
    left_d    = left;
    wr_d      = wr_q;
    rdp_d     = rdp_q;
    wd_d      = wd_q;
    sclk_d    = sclk_q;
    cs_d      = cs_n_q;
    done_d    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    tx_load   = 1'b0;
    tx_byte   = '0;
    tx_shift  = 1'b0;
    rx_clear  = 1'b0;
    rx_sample = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = T_CSS;
          cs_d     = 1'b0;
          wr_d     = req_write;
          left_d   = eff_count;
          wd_d     = req_wdata;
          rdp_d    = 1'b0;
          bit_d    = '0;
          tx_load  = 1'b1;
          tx_byte  = make_cmd(req_write, req_addr);
          rx_clear = 1'b1;
        end
      end
      ST_SETUP, ST_GAP: begin
        if (tmr_zero) begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          state_d   = ST_LOW;
          sclk_d    = 1'b0;
          tmr_load  = 1'b1;
          tmr_val   = T_HALF;
          rx_sample = rdp_q;
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
          if (bitc != LAST_BIT) begin
            bit_d    = bitc + 1'b1;
            tx_shift = 1'b1;
            state_d  = ST_HIGH;
            tmr_val  = T_HALF;
          end else begin
            bit_d = '0;
            if (left != '0) begin
              left_d  = left - 1'b1;
              tx_load = 1'b1;
              tx_byte = wr_q ? data_byte : '0;
              rdp_d   = !wr_q;
              state_d = ST_GAP;
              tmr_val = T_GAP;
            end else begin
              rdp_d   = 1'b0;
              state_d = ST_HOLD;
              tmr_val = T_CSH;
            end
          end
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          cs_d     = 1'b1;
          done_d   = 1'b1;
          state_d  = ST_REST;
          tmr_load = 1'b1;
          tmr_val  = T_XFER;
        end
      end
      ST_REST: begin
        if (tmr_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitc   <= '0;
      left   <= '0;
      wr_q   <= 1'b0;
      rdp_q  <= 1'b0;
      wd_q   <= '0;
      sclk_q <= 1'b1;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      state  <= state_d;
      bitc   <= bit_d;
      left   <= left_d;
      wr_q   <= wr_d;
      rdp_q  <= rdp_d;
      wd_q   <= wd_d;
      sclk_q <= sclk_d;
      cs_n_q <= cs_d;
      done_q <= done_d;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = done_q;
  assign ser_clk   = sclk_q;
  assign ser_cs_n  = cs_n_q;

  // R2: a taken request starts a transfer on the next edge
  a_r2_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !ser_cs_n && !req_ready);

  // R6: inside a transfer MOSI moves only with a rising SCLK
  a_r6_mosi_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs_n && !$past(ser_cs_n) && !$stable(ser_mosi) |-> $rose(ser_clk));

  // R7: SCLK falls only while chip-select is low
  a_r7_fall_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> !ser_cs_n);

  // R10: chip-select rises with SCLK resting high
  a_r10_cs_rise_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cs_n) |-> ser_clk);

  // R11: the response strobe coincides with chip-select rising and lasts one cycle
  a_r11_strobe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(ser_cs_n));

  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sim_sreg_host.sv
`timescale 1ns/1ps
module sim_sreg_host;

  localparam int HALF = 19;
  localparam int CSS  = 3;
  localparam int CSH  = 13;
  localparam int GAP  = 500;
  localparam int XFER = 800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [1:0]  req_count = '0;
  logic [23:0] req_wdata = '0;
  logic        rsp_valid;
  logic [23:0] rsp_rdata;
  logic        ser_cs_n, ser_clk, ser_mosi;
  logic        ser_miso = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sreg_host u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_count(req_count), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_mosi(ser_mosi), .ser_miso(ser_miso)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [23:0] pval(input logic [4:0] a);
    return 24'h3C5A96 ^ ({19'd0, a} * 24'h01F7D3);
  endfunction

  function automatic logic [23:0] nmask(input int n);
    return (n >= 3) ? 24'hFFFFFF : ((24'h1 << (8 * n)) - 24'h1);
  endfunction

  // ---------------- peripheral model ----------------
  int          cur_n = 1;
  int          pfc = 0;
  logic [7:0]  pcmd = '0;

  always @(negedge ser_cs_n) begin
    pfc = 0;
    ser_miso = 1'b0;
  end

  always @(negedge ser_clk) begin
    if (ser_cs_n === 1'b0) begin
      if (pfc < 8) pcmd = {pcmd[6:0], ser_mosi};
      pfc++;
    end
  end

  always @(posedge ser_clk) begin
    if (ser_cs_n === 1'b0 && pfc >= 8 && !pcmd[7]) begin
      automatic int idx = 8 * cur_n - 1 - (pfc - 8);
      automatic logic [23:0] v = pval(pcmd[4:0]);
      ser_miso = (idx >= 0) ? v[idx] : 1'b0;
    end
  end

  // ---------------- bus monitor ----------------
  logic p_cs = 1'b1, p_sclk = 1'b1, p_mosi = 1'b0, p_ready = 1'b1;
  int since_csfall = 0, since_rise = 0, since_fall = 0, since_csrise = 1000000;
  int falls = 0, ncap = 0, cs_falls = 0;
  bit xfer_seen = 0;
  logic [7:0] curbyte = '0;
  logic [7:0] cap [4];

  always @(negedge clk) begin
    if (!rst_n) begin
      p_cs = 1'b1; p_sclk = 1'b1; p_mosi = 1'b0; p_ready = 1'b1;
    end else begin
      since_csfall++; since_rise++; since_fall++; since_csrise++;
      if (!ser_cs_n && p_cs) begin
        if (xfer_seen) check(since_csrise >= XFER, "R12 chip-select idle time", since_csrise, XFER);
        since_csfall = 0; falls = 0; ncap = 0; cs_falls++;
      end
      if (!ser_cs_n && !p_cs && ser_mosi !== p_mosi)
        check(ser_clk && !p_sclk, "R6 MOSI moved without rising SCLK", {p_sclk, ser_clk}, 2'b01);
      if (!ser_clk && p_sclk) begin
        falls++;
        check(ser_mosi === p_mosi, "R6 MOSI unstable at falling SCLK", ser_mosi, p_mosi);
        if (falls == 1)
          check(since_csfall == CSS + HALF, "R8 CS fall to first SCLK fall", since_csfall, CSS + HALF);
        else if ((falls - 1) % 8 == 0)
          check(since_rise == GAP + HALF, "R9 inter-byte gap", since_rise, GAP + HALF);
        else
          check(since_rise == HALF, "R7 SCLK high phase", since_rise, HALF);
        curbyte = {curbyte[6:0], ser_mosi};
        if (falls % 8 == 0 && falls / 8 <= 4) begin
          cap[falls/8 - 1] = curbyte;
          ncap = falls / 8;
        end
        since_fall = 0;
      end
      if (ser_clk && !p_sclk) begin
        check(since_fall == HALF, "R7 SCLK low phase", since_fall, HALF);
        since_rise = 0;
      end
      if (ser_cs_n && !p_cs) begin
        check(since_fall == HALF + CSH, "R10 CS hold after last fall", since_fall, HALF + CSH);
        check(ser_clk == 1'b1, "R10 SCLK high at CS rise", ser_clk, 1);
        check(rsp_valid == 1'b1, "R11 strobe at CS rise", rsp_valid, 1);
        since_csrise = 0;
        xfer_seen = 1;
      end else if (rsp_valid) begin
        check(0, "R11 strobe without CS rise", 1, 0);
      end
      if (req_ready && !p_ready && xfer_seen)
        check(since_csrise == XFER, "R12 ready return", since_csrise, XFER);
      p_cs = ser_cs_n; p_sclk = ser_clk; p_mosi = ser_mosi; p_ready = req_ready;
    end
  end

  // ---------------- driver ----------------
  task automatic do_xfer(input bit wr, input logic [4:0] addr, input logic [1:0] cnt,
                         input logic [23:0] wdata, input bit spur);
    automatic int n = (cnt == 0) ? 1 : int'(cnt);
    automatic int start_falls;
    automatic logic [23:0] got;
    automatic logic [7:0] eb;
    cur_n = n;
    while (!req_ready) @(negedge clk);
    start_falls = cs_falls;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_count = cnt; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0 && ser_cs_n == 1'b0, "R2 busy after accept", {req_ready, ser_cs_n}, 0);
    if (spur) begin
      req_valid = 1'b1; req_write = !wr; req_addr = ~addr; req_count = 2'd3; req_wdata = ~wdata;
      repeat (40) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!rsp_valid) @(negedge clk);
    got = rsp_rdata;
    @(negedge clk);
    check(cs_falls == start_falls + 1, "R2 one transfer per accepted request", cs_falls - start_falls, 1);
    if (cnt == 0) check(ncap == 2, "R13 count zero sends one byte", ncap, 2);
    check(ncap == n + 1, "R4 byte count on bus", ncap, n + 1);
    check(cap[0] == {wr, 2'b00, addr}, "R3 command byte", cap[0], {wr, 2'b00, addr});
    for (int k = 0; k < n && k < 3; k++) begin
      eb = wr ? wdata[8*(n-1-k) +: 8] : 8'h00;
      if (wr) check(cap[k+1] == eb, "R4 write data byte", cap[k+1], eb);
      else    check(cap[k+1] == eb, "R5 MOSI low during read data", cap[k+1], eb);
    end
    if (wr) check(got == 24'h0, "R5 read word zero after write", got, 0);
    else    check(got == (pval(addr) & nmask(n)), "R5 read word", got, pval(addr) & nmask(n));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(ser_cs_n == 1 && ser_clk == 1 && ser_mosi == 0, "R1 bus idle in reset",
          {ser_cs_n, ser_clk, ser_mosi}, 3'b110);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(req_ready == 1 && rsp_valid == 0, "R1 ready idle after reset", {req_ready, rsp_valid}, 2'b10);
    check(ser_cs_n == 1 && ser_clk == 1 && ser_mosi == 0, "R1 bus idle after reset",
          {ser_cs_n, ser_clk, ser_mosi}, 3'b110);

    do_xfer(1'b1, 5'h1F, 2'd3, 24'hA5C3F0, 1'b0);
    do_xfer(1'b0, 5'h00, 2'd1, 24'hFFFFFF, 1'b0);
    do_xfer(1'b0, 5'h15, 2'd3, 24'h000000, 1'b0);
    do_xfer(1'b1, 5'h0A, 2'd0, 24'hDEAD7E, 1'b0);
    do_xfer(1'b1, 5'h11, 2'd2, 24'h9B8001, 1'b1);
    do_xfer(1'b0, 5'h07, 2'd2, 24'h123456, 1'b1);
    for (int i = 0; i < 18; i++) begin
      automatic bit wr = 1'(($urandom % 2));
      automatic logic [4:0] a = 5'($urandom % 32);
      automatic logic [1:0] c = 2'(1 + ($urandom % 3));
      automatic logic [23:0] d = 24'($urandom);
      do_xfer(wr, a, c, d, 1'b0);
    end
    repeat (XFER + 10) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: transfers incomplete, actual cycles %0d expected fewer", 190000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule